// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block performs one of four single-bit operations on a 32-bit data word: force one bit high, force one bit low, flip one bit, or pull one bit out to the least significant position. The bit position comes either from a general register operand or from a short immediate field carried in the instruction. A two-bit operation code and a form select are the only decode the block needs. Fetch and any wider decode stay upstream.

The datapath is combinational. The parameter `REG_OUT` selects one of two variants. The first registers the result and the reserved flag, which adds one cycle of latency and gives a clean timing boundary. The second leaves the outputs combinational, so they are valid in the same cycle as the inputs. Register-form indices are always taken modulo the word width. An immediate whose top bit is set cannot address a bit of a 32-bit word, so the block treats it as a reserved encoding: it raises a flag for the exception logic and forces the result to zero.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 2'b00 (clear) returns the source with the selected bit forced to 0 and all other bits unchanged.
- R2: Operation code 2'b11 (set) returns the source with the selected bit forced to 1 and all other bits unchanged.
- R3: Operation code 2'b10 (invert) returns the source with the selected bit complemented and all other bits unchanged.
- R4: Operation code 2'b01 (extract) returns the selected source bit in result bit 0, and result bits 31..1 are zero.
- R5: In register form (`use_imm_i`=0), the index is `idx_reg_i[4:0]`. Bits 31..5 of `idx_reg_i` have no effect on the result or on the flag.
- R6: In immediate form (`use_imm_i`=1), when `imm_i[5]`=0 the index is `imm_i[4:0]`.
- R7: In immediate form with `imm_i[5]`=1, `reserved_o` is 1 and the result is all zeros. In every other case `reserved_o` is 0.
- R8: With `REG_OUT`=0, the result and the flag follow the inputs in the same cycle, with no clock edge in between.
- R9: With `REG_OUT`=1, the outputs show the values for the inputs present at the previous rising clock edge. While `rst_n` is low at a rising edge, the outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Source data word |
| idx_reg_i | input | 32 | Register operand that carries the bit index |
| imm_i | input | 6 | Immediate index field |
| use_imm_i | input | 1 | 1 selects the immediate form, 0 selects the register form |
| op_i | input | 2 | Operation code: 00 clear, 01 extract, 10 invert, 11 set |
| result_o | output | 32 | Operation result |
| reserved_o | output | 1 | Reserved immediate encoding detected |

## Verification
The assertions assume that every input is a known value at each rising edge after reset. They also assume that, in the registered variant, the values captured at an edge are the values the output register took at that same edge. No assumption limits the index, so both forms may carry any value in any bit. The stimulus drives all inputs to defined values from time zero and changes them only on falling edges. It covers the legal index range in both forms and adds register operands with random upper bits and immediates with the top bit set, so the reserved path and the masking path both run.

// File: rtl/bitop_pkg.sv
// Package: shared operation codes for the single-bit manipulation unit.
// Assumes the operation field is two bits wide.
package bitop_pkg;

    typedef enum logic [1:0] {
        OP_CLR = 2'b00,
        OP_EXT = 2'b01,
        OP_INV = 2'b10,
        OP_SET = 2'b11
    } bitop_op_e;

endpackage

// File: rtl/bitop_index_sel.sv
// Module: picks the bit index from the register operand or the immediate field.
// It also flags immediate values too wide to address a data bit.
// Assumes IMM_W >= IDX_W.
module bitop_index_sel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 6,
    localparam int IDX_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  idx_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             reserved_o
);

    logic unused_reg_hi;

    // Upper register bits are dropped on purpose (modulo indexing).
    assign unused_reg_hi = ^idx_reg_i[XLEN-1:IDX_W];

    // Index multiplexer between the two forms.
    always_comb begin
        if (use_imm_i) idx_o = imm_i[IDX_W-1:0];
        else           idx_o = idx_reg_i[IDX_W-1:0];
    end

    // Reserved detection exists only where the immediate is wider than the index.
    generate
        if (IMM_W > IDX_W) begin : g_rsv
            assign reserved_o = use_imm_i & (|imm_i[IMM_W-1:IDX_W]);
        end else begin : g_norsv
            assign reserved_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bitop_mask_gen.sv
// Module: decodes a binary bit index into a one-hot mask of XLEN bits.
// Assumes idx_i < XLEN, which a power-of-two XLEN guarantees.
module bitop_mask_gen #(
    parameter int XLEN = 32,
    localparam int IDX_W = $clog2(XLEN)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [XLEN-1:0]  mask_o
);

    // One comparator per bit position.
    generate
        for (genvar g = 0; g < XLEN; g++) begin : g_bit
            assign mask_o[g] = (idx_i == IDX_W'(g));
        end
    endgenerate

endmodule

// File: rtl/bitop_alu.sv
// Module: applies the selected operation to the source word using a one-hot mask.
// It zeroes the result when kill_i is set.
// Assumes mask_i is one-hot.
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] mask_i,
    input  logic [1:0]      op_i,
    input  logic            kill_i,
    output logic [XLEN-1:0] res_o
);

    bitop_op_e       op_e;
    logic            picked;
    logic [XLEN-1:0] raw;

    assign op_e   = bitop_op_e'(op_i);
    assign picked = |(src_i & mask_i);

    // Operation selection.
    always_comb begin
        case (op_e)
            OP_CLR:  raw = src_i & ~mask_i;
            OP_SET:  raw = src_i | mask_i;
            OP_INV:  raw = src_i ^ mask_i;
            OP_EXT:  raw = {{(XLEN-1){1'b0}}, picked};
            default: raw = '0;
        endcase
    end

    // Reserved encodings yield zero.
    assign res_o = kill_i ? '0 : raw;

endmodule

// File: rtl/bitop_unit.sv
// Module: top of the single-bit manipulation unit.
// Index selection, mask decode and the operation feed an optional output register.
// Assumes a synchronous active-low reset. clk and rst_n are unused when REG_OUT = 0.
module bitop_unit #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 6,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  src_i,
    input  logic [XLEN-1:0]  idx_reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic [1:0]       op_i,
    output logic [XLEN-1:0]  result_o,
    output logic             reserved_o
);

    localparam int IDX_W = $clog2(XLEN);

    logic [IDX_W-1:0] idx;
    logic             rsv;
    logic [XLEN-1:0]  mask;
    logic [XLEN-1:0]  res;

    bitop_index_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_idx (
        .idx_reg_i (idx_reg_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .idx_o     (idx),
        .reserved_o(rsv)
    );

    bitop_mask_gen #(.XLEN(XLEN)) u_mask (
        .idx_i (idx),
        .mask_o(mask)
    );

    bitop_alu #(.XLEN(XLEN)) u_alu (
        .src_i (src_i),
        .mask_i(mask),
        .op_i  (op_i),
        .kill_i(rsv),
        .res_o (res)
    );

    // Output stage variant chosen by REG_OUT.
    generate
        if (REG_OUT) begin : g_reg
            logic [XLEN-1:0] res_q;
            logic            rsv_q;
            // Output register with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q <= '0;
                    rsv_q <= 1'b0;
                end else begin
                    res_q <= res;
                    rsv_q <= rsv;
                end
            end
            assign result_o   = res_q;
            assign reserved_o = rsv_q;
        end else begin : g_comb
            assign result_o   = res;
            assign reserved_o = rsv;
        end
    endgenerate

endmodule

// File: rtl/bitop_unit_chk.sv
// Module: assertion checker bound to bitop_unit.
// It keeps its own copy of the inputs when the output is registered.
// Assumes the inputs are known at every rising edge after reset.
module bitop_unit_chk
    import bitop_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 6,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  src_i,
    input logic [XLEN-1:0]  idx_reg_i,
    input logic [IMM_W-1:0] imm_i,
    input logic             use_imm_i,
    input logic [1:0]       op_i,
    input logic [XLEN-1:0]  result_o,
    input logic             reserved_o
);

    localparam int IDX_W = $clog2(XLEN);

    logic [XLEN-1:0]  s_src;
    logic [XLEN-1:0]  s_reg;
    logic [IMM_W-1:0] s_imm;
    logic             s_use;
    logic [1:0]       s_op;
    logic             s_ok;
    logic [IDX_W-1:0] s_idx;

    generate
        if (REG_OUT) begin : g_cap
            // Capture the inputs that the output register samples.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_src <= '0;
                    s_reg <= '0;
                    s_imm <= '0;
                    s_use <= 1'b0;
                    s_op  <= 2'b00;
                    s_ok  <= 1'b0;
                end else begin
                    s_src <= src_i;
                    s_reg <= idx_reg_i;
                    s_imm <= imm_i;
                    s_use <= use_imm_i;
                    s_op  <= op_i;
                    s_ok  <= 1'b1;
                end
            end
        end else begin : g_direct
            assign s_src = src_i;
            assign s_reg = idx_reg_i;
            assign s_imm = imm_i;
            assign s_use = use_imm_i;
            assign s_op  = op_i;
            assign s_ok  = 1'b1;
        end
    endgenerate

    assign s_idx = s_use ? s_imm[IDX_W-1:0] : s_reg[IDX_W-1:0];

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ok && reserved_o) |-> (result_o == '0)); // R7

    AST_RSV_ONLY_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ok && reserved_o) |-> (s_use && s_imm[IMM_W-1])); // R7

    AST_EXT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ok && !reserved_o && s_op == OP_EXT) |->
        (result_o[XLEN-1:1] == '0 && result_o[0] == s_src[s_idx])); // R4

    AST_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ok && !reserved_o && s_op == OP_SET) |-> result_o[s_idx]); // R2

    AST_CLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ok && !reserved_o && s_op == OP_CLR) |-> !result_o[s_idx]); // R1

    AST_INV_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ok && !reserved_o && s_op == OP_INV) |->
        (result_o[s_idx] != s_src[s_idx])); // R3

    AST_REG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ok && !s_use) |-> !reserved_o); // R5

endmodule

bind bitop_unit bitop_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = 32'h0;
    logic [31:0] ridx = 32'h0;
    logic [5:0]  imm = 6'h0;
    logic        use_imm = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] res_r, res_c;
    logic        rsv_r, rsv_c;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bitop_unit #(.XLEN(32), .IMM_W(6), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .idx_reg_i(ridx), .imm_i(imm),
        .use_imm_i(use_imm), .op_i(op), .result_o(res_r), .reserved_o(rsv_r)
    );

    bitop_unit #(.XLEN(32), .IMM_W(6), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .src_i(src), .idx_reg_i(ridx), .imm_i(imm),
        .use_imm_i(use_imm), .op_i(op), .result_o(res_c), .reserved_o(rsv_c)
    );

    // Reference model: returns {reserved, result}.
    function automatic logic [32:0] model(input logic [31:0] s, input logic [31:0] r,
                                          input logic [5:0] im, input logic u,
                                          input logic [1:0] o);
        logic [4:0]  ix;
        logic [31:0] v;
        if (u && im[5]) return {1'b1, 32'h0};
        ix = u ? im[4:0] : r[4:0];
        v  = s;
        case (o)
            2'b00: v[ix] = 1'b0;
            2'b11: v[ix] = 1'b1;
            2'b10: v[ix] = ~s[ix];
            default: v = {31'h0, s[ix]};
        endcase
        return {1'b0, v};
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply on a falling edge: check the combinational copy now, the registered one a cycle later.
    task automatic run(input logic [31:0] s, input logic [31:0] r, input logic [5:0] im,
                       input logic u, input logic [1:0] o, input string req);
        logic [32:0] e;
        src = s; ridx = r; imm = im; use_imm = u; op = o;
        e = model(s, r, im, u, o);
        #1;
        check({req, " R8 comb"}, {rsv_c, res_c}, e);
        @(negedge clk);
        check({req, " R9 reg"}, {rsv_r, res_r}, e);
    endtask

    function automatic string opname(input logic [1:0] o);
        case (o)
            2'b00: return "R1 clear";
            2'b11: return "R2 set";
            2'b10: return "R3 invert";
            default: return "R4 extract";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        // R9: reset holds the registered outputs at zero.
        src = 32'hFFFF_FFFF; op = 2'b11; ridx = 32'd7;
        repeat (3) @(negedge clk);
        check("R9 reset", {rsv_r, res_r}, 33'h0);
        rst_n = 1'b1;

        // Sweep every index for every op in both forms (R1..R6).
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 32; i++) begin
                run($urandom, {$urandom, 5'(i)} >> 0, 6'h0, 1'b0, 2'(o), {opname(2'(o)), " R5 reg"});
                run($urandom, 32'h0, 6'(i), 1'b1, 2'(o), {opname(2'(o)), " R6 imm"});
            end
        end

        // R5: random upper register bits change nothing.
        for (int k = 0; k < 40; k++) begin
            logic [31:0] s;
            logic [4:0]  ix;
            logic [1:0]  o;
            s = $urandom; ix = 5'($urandom); o = 2'($urandom);
            run(s, {27'($urandom), ix}, 6'($urandom), 1'b0, o, "R5 upper bits");
            run(s, {27'h0, ix}, 6'h0, 1'b0, o, "R5 baseline");
        end

        // R7: reserved immediate encodings.
        run(32'hFFFF_FFFF, 32'h0, 6'h20, 1'b1, 2'b11, "R7 rsv set");
        run(32'hA5A5_A5A5, 32'h0, 6'h3F, 1'b1, 2'b01, "R7 rsv extract");
        run(32'h1234_5678, 32'h0, 6'h25, 1'b1, 2'b10, "R7 rsv invert");
        run(32'h1234_5678, 32'h20, 6'h20, 1'b0, 2'b11, "R7 reg form not reserved");

        // Directed corners.
        run(32'h0, 32'd31, 6'h0, 1'b0, 2'b11, "R2 top bit");
        run(32'hFFFF_FFFF, 32'd0, 6'h0, 1'b0, 2'b00, "R1 bit zero");
        run(32'h8000_0000, 32'h0, 6'd31, 1'b1, 2'b01, "R4 top bit");

        // R9: reset after activity clears the registered outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset again", {rsv_r, res_r}, 33'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule